// File: doc/BRIEF.md
# ATA Drive Task-File Register Block

This block sits on the device side of an ATA link and holds the task-file registers of one drive. A host-facing access port carries one access per cycle: a read or write, a selector between the command block and the control block, a 3-bit register offset and a width flag for 16-bit transfers. The block stores the sector count, sector number, cylinder and drive/head parameters, the last command code, the 16-bit data port, the status byte and the error byte, and returns read data one cycle after the access.

A separate protocol state machine, outside this block, consumes single-cycle event strobes (command written, drive/head written, data port read, data port written, status read, soft reset entered, soft reset released) and updates status, error and the data port through a load interface. The block itself tracks the soft-reset state and the interrupt-disable flag held in the device control register, and it flags any access to an offset or with a width it does not support through a sticky error output.

Top module: `ata_taskfile`

## Requirements
- R1: After a synchronous reset, status reads 0x40 (drive-ready, bit 6, alone), the error register reads 0x01, the parameter registers read 0x00, and `srst_active`, `nien` and `acc_err` are 0 with no event strobe raised.
- R2: Byte writes to command-block offsets 2 to 6 (sector count, sector number, cylinder low, cylinder high, drive/head) are stored and read back unchanged at the same offset.
- R3: At command-block offset 1 a read returns the error register; a write (features) is accepted, raises no error and changes no stored value.
- R4: A byte write to command-block offset 7 stores the command code on `cmd_code` and pulses `ev_cmd`; a byte write to offset 6 pulses `ev_sel`.
- R5: Command-block offset 0 is the 16-bit data port and only accepts wide accesses: a wide write stores all 16 bits and pulses `ev_data_wr`, a wide read returns the stored word and pulses `ev_data_rd`.
- R6: A read of command-block offset 7 returns status and pulses `ev_stat_rd`; a read of control-block offset 6 (alternate status) returns the same value with no event.
- R7: A write to control-block offset 6 (device control) with bit 2 set sets `srst_active` and pulses `ev_srst_set`, on every such write.
- R8: A device-control write with bit 2 clear while `srst_active` is 1 pulses `ev_srst_clr` and clears `srst_active`; with `srst_active` at 0 it raises no event.
- R9: Every device-control write copies bit 1 of the written byte onto `nien`.
- R10: A byte access to offset 0, a wide access to any other offset, or a control-block access to an offset other than 6 sets `acc_err`, which then stays 1 until reset; the access changes no register, raises no event and returns no read data.
- R11: Read data appears on `host_rdata` with `host_rvalid` high in the cycle after a legal read (byte reads zero the upper byte); every event strobe is one cycle wide, in the cycle after its access.
- R12: The protocol side loads status, error and the data port through `sm_stat_we`, `sm_err_we` and `sm_data_we`; the loaded value is what later host reads return.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_valid | input | 1 | Access request this cycle |
| host_write | input | 1 | 1 write, 0 read |
| host_ctl | input | 1 | 1 control block, 0 command block |
| host_wide | input | 1 | 1 for a 16-bit access |
| host_ofs | input | 3 | Register offset |
| host_wdata | input | 16 | Write data (byte accesses use bits 7:0) |
| host_rdata | output | 16 | Read data |
| host_rvalid | output | 1 | Read data valid |
| sm_stat_we | input | 1 | Load status from protocol side |
| sm_stat | input | 8 | Status value to load |
| sm_err_we | input | 1 | Load error register |
| sm_err | input | 8 | Error value to load |
| sm_data_we | input | 1 | Load data port |
| sm_data | input | 16 | Data port value to load |
| cmd_code | output | 8 | Last command code written |
| ev_cmd | output | 1 | Command written strobe |
| ev_sel | output | 1 | Drive/head written strobe |
| ev_data_rd | output | 1 | Data port read strobe |
| ev_data_wr | output | 1 | Data port written strobe |
| ev_stat_rd | output | 1 | Status read strobe |
| ev_srst_set | output | 1 | Soft reset entered strobe |
| ev_srst_clr | output | 1 | Soft reset released strobe |
| srst_active | output | 1 | Soft reset state |
| nien | output | 1 | Interrupt-disable flag |
| acc_err | output | 1 | Sticky illegal-access flag |

## Verification
On every cycle the assertions check that at most one event strobe fires, that read data only follows a host read, that wide read data only comes from the data port, that the soft-reset strobes agree with the soft-reset state and that the error flag stays set and silent. What the stored registers hold, that alternate status and status return the same byte with different side effects, that features writes leave everything untouched and that illegal accesses do not disturb the parameters can only be shown by the bench's write-then-read scenarios and its scoreboard of expected read data.

// File: rtl/ata_tf_pkg.sv
// Package: shared offsets, bit positions and decode types of the
// task-file register block. Assumes a 3-bit offset and byte registers.
package ata_tf_pkg;
    localparam int BYTE_W    = 8;
    localparam int WORD_W    = 16;
    localparam int OFS_W     = 3;
    localparam int N_PAR     = 5;             // offsets 2..6
    localparam int PAR_BASE  = 2;
    localparam int PAR_DRVHD = N_PAR - 1;     // drive/head is the last one

    localparam logic [OFS_W-1:0] OFS_DATA    = 3'd0;
    localparam logic [OFS_W-1:0] OFS_ERRFEAT = 3'd1;
    localparam logic [OFS_W-1:0] OFS_STATCMD = 3'd7;
    localparam logic [OFS_W-1:0] OFS_DEVCTL  = 3'd6;

    localparam int SRST_BIT = 2;
    localparam int NIEN_BIT = 1;
    localparam int DRDY_BIT = 6;

    localparam logic [BYTE_W-1:0] STAT_RST = BYTE_W'(1) << DRDY_BIT;
    localparam logic [BYTE_W-1:0] ERR_RST  = 8'h01;

    // Read strobes produced by the decoder, one per readable register
    typedef struct packed {
        logic             data;
        logic             err;
        logic             stat;
        logic             alt;
        logic [N_PAR-1:0] par;
    } tf_rd_t;
endpackage

// File: rtl/ata_tf_decode.sv
// Decoder: classifies one host access into a read strobe, a write strobe
// or an illegal access. Purely combinational; assumes at most one access
// per cycle. Features writes are legal but raise no strobe.
module ata_tf_decode
    import ata_tf_pkg::*;
(
    input  logic               req_valid,
    input  logic               req_write,
    input  logic               req_ctl,
    input  logic               req_wide,
    input  logic [OFS_W-1:0]   req_ofs,
    output tf_rd_t             rd,
    output logic               wr_data,
    output logic               wr_cmd,
    output logic [N_PAR-1:0]   wr_par,
    output logic               wr_devctl,
    output logic               illegal
);
    // Offset and width classification of the current access
    always_comb begin
        rd        = '0;
        wr_data   = 1'b0;
        wr_cmd    = 1'b0;
        wr_par    = '0;
        wr_devctl = 1'b0;
        illegal   = 1'b0;
        if (req_valid) begin
            if (req_ctl) begin
                if (req_ofs == OFS_DEVCTL && !req_wide) begin
                    if (req_write) wr_devctl = 1'b1;
                    else           rd.alt    = 1'b1;
                end else begin
                    illegal = 1'b1;
                end
            end else if (req_ofs == OFS_DATA) begin
                if (!req_wide)      illegal   = 1'b1;
                else if (req_write) wr_data   = 1'b1;
                else                rd.data   = 1'b1;
            end else if (req_wide) begin
                illegal = 1'b1;
            end else if (req_ofs == OFS_ERRFEAT) begin
                if (!req_write) rd.err = 1'b1;
            end else if (req_ofs == OFS_STATCMD) begin
                if (req_write) wr_cmd  = 1'b1;
                else           rd.stat = 1'b1;
            end else begin
                for (int k = 0; k < N_PAR; k++) begin
                    if (req_ofs == OFS_W'(k + PAR_BASE)) begin
                        if (req_write) wr_par[k] = 1'b1;
                        else           rd.par[k] = 1'b1;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/ata_tf_regs.sv
// Register file: parameter bytes, command code, data port, status and
// error, plus the registered read mux. Assumes decoded one-hot strobes.
// A host data write wins over a same-cycle protocol load of the data port.
module ata_tf_regs
    import ata_tf_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  tf_rd_t             rd,
    input  logic               wr_data,
    input  logic               wr_cmd,
    input  logic [N_PAR-1:0]   wr_par,
    input  logic [WORD_W-1:0]  wdata,
    input  logic               sm_stat_we,
    input  logic [BYTE_W-1:0]  sm_stat,
    input  logic               sm_err_we,
    input  logic [BYTE_W-1:0]  sm_err,
    input  logic               sm_data_we,
    input  logic [WORD_W-1:0]  sm_data,
    output logic [BYTE_W-1:0]  cmd_q,
    output logic [WORD_W-1:0]  rdata,
    output logic               rvalid
);
    logic [N_PAR-1:0][BYTE_W-1:0] par_q;
    logic [BYTE_W-1:0]            stat_q;
    logic [BYTE_W-1:0]            err_q;
    logic [WORD_W-1:0]            data_q;

    // One storage byte per parameter register
    for (genvar k = 0; k < N_PAR; k++) begin : g_par
        logic [BYTE_W-1:0] q;
        // Capture a host byte write to this parameter
        always_ff @(posedge clk) begin
            if (!rst_n)         q <= '0;
            else if (wr_par[k]) q <= wdata[BYTE_W-1:0];
        end
        assign par_q[k] = q;
    end

    // Command code captured on a command write
    always_ff @(posedge clk) begin
        if (!rst_n)      cmd_q <= '0;
        else if (wr_cmd) cmd_q <= wdata[BYTE_W-1:0];
    end

    // Status and error are owned by the protocol side
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= STAT_RST;
            err_q  <= ERR_RST;
        end else begin
            if (sm_stat_we) stat_q <= sm_stat;
            if (sm_err_we)  err_q  <= sm_err;
        end
    end

    // Data port: host write has priority over a protocol load
    always_ff @(posedge clk) begin
        if (!rst_n)          data_q <= '0;
        else if (wr_data)    data_q <= wdata;
        else if (sm_data_we) data_q <= sm_data;
    end

    // Registered read mux, one cycle after the access
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid <= 1'b0;
            rdata  <= '0;
        end else begin
            rvalid <= |rd;
            rdata  <= '0;
            if (rd.data)           rdata <= data_q;
            if (rd.err)            rdata <= WORD_W'(err_q);
            if (rd.stat || rd.alt) rdata <= WORD_W'(stat_q);
            for (int k = 0; k < N_PAR; k++)
                if (rd.par[k]) rdata <= WORD_W'(par_q[k]);
        end
    end
endmodule

// File: rtl/ata_tf_ctl.sv
// Control and events: soft-reset state, interrupt-disable flag, sticky
// access error and the single-cycle event strobes to the protocol side.
// Assumes decoded, mutually exclusive strobes at its inputs.
module ata_tf_ctl (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_cmd,
    input  logic wr_sel,
    input  logic wr_data,
    input  logic rd_data,
    input  logic rd_stat,
    input  logic wr_devctl,
    input  logic srst_bit,
    input  logic nien_bit,
    input  logic illegal,
    output logic ev_cmd,
    output logic ev_sel,
    output logic ev_data_rd,
    output logic ev_data_wr,
    output logic ev_stat_rd,
    output logic ev_srst_set,
    output logic ev_srst_clr,
    output logic srst_active,
    output logic nien,
    output logic acc_err
);
    logic set_now;
    logic clr_now;

    assign set_now = wr_devctl && srst_bit;
    assign clr_now = wr_devctl && !srst_bit && srst_active;

    // Register the access events as one-cycle strobes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ev_cmd      <= 1'b0;
            ev_sel      <= 1'b0;
            ev_data_rd  <= 1'b0;
            ev_data_wr  <= 1'b0;
            ev_stat_rd  <= 1'b0;
            ev_srst_set <= 1'b0;
            ev_srst_clr <= 1'b0;
        end else begin
            ev_cmd      <= wr_cmd;
            ev_sel      <= wr_sel;
            ev_data_rd  <= rd_data;
            ev_data_wr  <= wr_data;
            ev_stat_rd  <= rd_stat;
            ev_srst_set <= set_now;
            ev_srst_clr <= clr_now;
        end
    end

    // Soft-reset state and interrupt-disable flag from device control
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            srst_active <= 1'b0;
            nien        <= 1'b0;
        end else if (wr_devctl) begin
            nien <= nien_bit;
            if (set_now)      srst_active <= 1'b1;
            else if (clr_now) srst_active <= 1'b0;
        end
    end

    // Sticky illegal-access flag, cleared only by reset
    always_ff @(posedge clk) begin
        if (!rst_n)       acc_err <= 1'b0;
        else if (illegal) acc_err <= 1'b1;
    end

    AST_SRST_SET_ENTERS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_srst_set |-> srst_active);                         // R7
    AST_SRST_CLR_LEAVES: assert property (@(posedge clk) disable iff (!rst_n)
        ev_srst_clr |-> !srst_active && $past(srst_active));  // R8
    AST_SRST_STATE_MOVES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(srst_active) |-> ev_srst_set);                  // R7
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |=> acc_err);                                 // R10
endmodule

// File: rtl/ata_taskfile.sv
// Top: one drive's task-file register block. Wires the decoder, the
// register file and the control/event logic. Assumes one host access
// per cycle; read data returns one cycle later.
module ata_taskfile
    import ata_tf_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        host_valid,
    input  logic        host_write,
    input  logic        host_ctl,
    input  logic        host_wide,
    input  logic [2:0]  host_ofs,
    input  logic [15:0] host_wdata,
    output logic [15:0] host_rdata,
    output logic        host_rvalid,
    input  logic        sm_stat_we,
    input  logic [7:0]  sm_stat,
    input  logic        sm_err_we,
    input  logic [7:0]  sm_err,
    input  logic        sm_data_we,
    input  logic [15:0] sm_data,
    output logic [7:0]  cmd_code,
    output logic        ev_cmd,
    output logic        ev_sel,
    output logic        ev_data_rd,
    output logic        ev_data_wr,
    output logic        ev_stat_rd,
    output logic        ev_srst_set,
    output logic        ev_srst_clr,
    output logic        srst_active,
    output logic        nien,
    output logic        acc_err
);
    tf_rd_t           rd;
    logic             wr_data;
    logic             wr_cmd;
    logic [N_PAR-1:0] wr_par;
    logic             wr_devctl;
    logic             illegal;

    ata_tf_decode i_decode (
        .req_valid (host_valid),
        .req_write (host_write),
        .req_ctl   (host_ctl),
        .req_wide  (host_wide),
        .req_ofs   (host_ofs),
        .rd        (rd),
        .wr_data   (wr_data),
        .wr_cmd    (wr_cmd),
        .wr_par    (wr_par),
        .wr_devctl (wr_devctl),
        .illegal   (illegal)
    );

    ata_tf_regs i_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd         (rd),
        .wr_data    (wr_data),
        .wr_cmd     (wr_cmd),
        .wr_par     (wr_par),
        .wdata      (host_wdata),
        .sm_stat_we (sm_stat_we),
        .sm_stat    (sm_stat),
        .sm_err_we  (sm_err_we),
        .sm_err     (sm_err),
        .sm_data_we (sm_data_we),
        .sm_data    (sm_data),
        .cmd_q      (cmd_code),
        .rdata      (host_rdata),
        .rvalid     (host_rvalid)
    );

    ata_tf_ctl i_ctl (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_cmd      (wr_cmd),
        .wr_sel      (wr_par[PAR_DRVHD]),
        .wr_data     (wr_data),
        .rd_data     (rd.data),
        .rd_stat     (rd.stat),
        .wr_devctl   (wr_devctl),
        .srst_bit    (host_wdata[SRST_BIT]),
        .nien_bit    (host_wdata[NIEN_BIT]),
        .illegal     (illegal),
        .ev_cmd      (ev_cmd),
        .ev_sel      (ev_sel),
        .ev_data_rd  (ev_data_rd),
        .ev_data_wr  (ev_data_wr),
        .ev_stat_rd  (ev_stat_rd),
        .ev_srst_set (ev_srst_set),
        .ev_srst_clr (ev_srst_clr),
        .srst_active (srst_active),
        .nien        (nien),
        .acc_err     (acc_err)
    );

    AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ev_cmd, ev_sel, ev_data_rd, ev_data_wr, ev_stat_rd,
                  ev_srst_set, ev_srst_clr}));                 // R11
    AST_RVALID_AFTER_READ: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid |-> $past(host_valid && !host_write));    // R11
    AST_WIDE_DATA_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        host_rvalid && $past(host_wide) |->
            $past(!host_ctl && host_ofs == OFS_DATA));        // R5
    AST_ILLEGAL_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_err) |-> !host_rvalid && !ev_cmd && !ev_sel && !ev_data_wr
                           && !ev_srst_set && !ev_srst_clr);  // R10
endmodule

// File: tb/test_ata_taskfile.sv
// Scoreboard bench: the access task pushes expected read data into a
// queue, a monitor pops and compares whenever read data comes back.
module test_ata_taskfile;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_valid = 1'b0, host_write = 1'b0, host_ctl = 1'b0, host_wide = 1'b0;
    logic [2:0]  host_ofs = '0;
    logic [15:0] host_wdata = '0;
    logic [15:0] host_rdata;
    logic        host_rvalid;
    logic        sm_stat_we = 1'b0, sm_err_we = 1'b0, sm_data_we = 1'b0;
    logic [7:0]  sm_stat = '0, sm_err = '0;
    logic [15:0] sm_data = '0;
    logic [7:0]  cmd_code;
    logic        ev_cmd, ev_sel, ev_data_rd, ev_data_wr, ev_stat_rd, ev_srst_set, ev_srst_clr;
    logic        srst_active, nien, acc_err;

    // event vector order: srst_clr srst_set stat_rd data_wr data_rd sel cmd
    localparam logic [6:0] E_NONE = 7'd0, E_CMD = 7'd1, E_SEL = 7'd2, E_DRD = 7'd4,
                           E_DWR = 7'd8, E_STAT = 7'd16, E_SET = 7'd32, E_CLR = 7'd64;

    int n_chk = 0, n_bad = 0;
    logic [15:0] exp_q[$];
    string       tag_q[$];
    bit          done = 1'b0;

    always #2 clk = ~clk;

    ata_taskfile i_ata_taskfile (.*);

    wire [6:0] ev_vec = {ev_srst_clr, ev_srst_set, ev_stat_rd, ev_data_wr,
                         ev_data_rd, ev_sel, ev_cmd};

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // Monitor: compares returned read data against the scoreboard queue
    always @(negedge clk) begin
        if (rst_n && host_rvalid) begin
            if (exp_q.size() == 0) begin
                n_chk++; n_bad++;
                $display("FAIL R10/R11 unexpected read data: actual %h expected none", host_rdata);
            end else begin
                check(tag_q.pop_front(), host_rdata, exp_q.pop_front());
            end
        end
    end

    // Driver: one access, pushes expected read data, then checks events
    task automatic acc(input bit wr, input bit ctl, input bit wide, input logic [2:0] ofs,
                       input logic [15:0] wd, input bit exp_rd, input logic [15:0] rd_val,
                       input logic [6:0] exp_ev, input string tag);
        @(negedge clk);
        host_valid = 1'b1; host_write = wr; host_ctl = ctl; host_wide = wide;
        host_ofs = ofs; host_wdata = wd;
        if (exp_rd) begin
            exp_q.push_back(rd_val);
            tag_q.push_back({tag, " read data"});
        end
        @(negedge clk);
        host_valid = 1'b0;
        check({tag, " events"}, 16'(ev_vec), 16'(exp_ev));
    endtask

    task automatic sm_load(input bit s, input logic [7:0] sv, input bit e,
                           input logic [7:0] ev, input bit d, input logic [15:0] dv);
        @(negedge clk);
        sm_stat_we = s; sm_stat = sv; sm_err_we = e; sm_err = ev; sm_data_we = d; sm_data = dv;
        @(negedge clk);
        sm_stat_we = 1'b0; sm_err_we = 1'b0; sm_data_we = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            if (exp_q.size() != 0) begin
                n_chk++; n_bad++;
                $display("FAIL R11 missing read data: actual none expected %0d items", exp_q.size());
            end
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        do_reset();
        @(negedge clk);
        // R1 reset state
        check("R1 srst_active", 16'(srst_active), 16'd0);
        check("R1 nien", 16'(nien), 16'd0);
        check("R1 acc_err", 16'(acc_err), 16'd0);
        check("R1 events", 16'(ev_vec), 16'd0);
        acc(0, 0, 0, 3'd7, 0, 1, 16'h0040, E_STAT, "R1 status");
        acc(0, 0, 0, 3'd1, 0, 1, 16'h0001, E_NONE, "R1 error");
        for (int k = 2; k <= 6; k++)
            acc(0, 0, 0, 3'(k), 0, 1, 16'h0000, E_NONE, "R1 param");

        // R2 parameter write and read back
        for (int k = 2; k <= 6; k++)
            acc(1, 0, 0, 3'(k), 16'(8'h30 + 8'(k * 17)), 0, 0, (k == 6) ? E_SEL : E_NONE, "R2 write");
        for (int k = 2; k <= 6; k++)
            acc(0, 0, 0, 3'(k), 0, 1, 16'(8'h30 + 8'(k * 17)), E_NONE, "R2 readback");

        // R3 features write has no effect
        acc(1, 0, 0, 3'd1, 16'h00AB, 0, 0, E_NONE, "R3 features write");
        acc(0, 0, 0, 3'd1, 0, 1, 16'h0001, E_NONE, "R3 error unchanged");
        acc(0, 0, 0, 3'd2, 0, 1, 16'h0052, E_NONE, "R3 param unchanged");
        check("R3 acc_err", 16'(acc_err), 16'd0);

        // R4 command and drive/head writes
        acc(1, 0, 0, 3'd7, 16'h00EC, 0, 0, E_CMD, "R4 command");
        check("R4 cmd_code", 16'(cmd_code), 16'h00EC);
        acc(1, 0, 0, 3'd6, 16'h00A0, 0, 0, E_SEL, "R4 select");

        // R5 data port
        acc(1, 0, 1, 3'd0, 16'hBEEF, 0, 0, E_DWR, "R5 data write");
        acc(0, 0, 1, 3'd0, 0, 1, 16'hBEEF, E_DRD, "R5 data read");

        // R12 and R6 protocol loads, status versus alternate status
        sm_load(1, 8'h58, 1, 8'h04, 1, 16'h1234);
        acc(0, 1, 0, 3'd6, 0, 1, 16'h0058, E_NONE, "R6 alt status");
        acc(0, 0, 0, 3'd7, 0, 1, 16'h0058, E_STAT, "R6 status");
        acc(0, 0, 0, 3'd1, 0, 1, 16'h0004, E_NONE, "R12 error load");
        acc(0, 0, 1, 3'd0, 0, 1, 16'h1234, E_DRD, "R12 data load");

        // R7 R8 R9 device control
        acc(1, 1, 0, 3'd6, 16'h0002, 0, 0, E_NONE, "R8 clear outside reset");
        check("R9 nien set", 16'(nien), 16'd1);
        check("R8 srst idle", 16'(srst_active), 16'd0);
        acc(1, 1, 0, 3'd6, 16'h0004, 0, 0, E_SET, "R7 enter reset");
        check("R7 srst_active", 16'(srst_active), 16'd1);
        check("R9 nien cleared", 16'(nien), 16'd0);
        acc(1, 1, 0, 3'd6, 16'h0006, 0, 0, E_SET, "R7 repeat set");
        check("R9 nien again", 16'(nien), 16'd1);
        acc(1, 1, 0, 3'd6, 16'h0000, 0, 0, E_CLR, "R8 release");
        check("R8 srst_active", 16'(srst_active), 16'd0);
        acc(1, 1, 0, 3'd6, 16'h0000, 0, 0, E_NONE, "R8 no second clear");

        // R10 illegal accesses
        acc(0, 0, 0, 3'd0, 0, 0, 0, E_NONE, "R10 byte data read");
        check("R10 acc_err set", 16'(acc_err), 16'd1);
        acc(1, 0, 1, 3'd2, 16'hFFFF, 0, 0, E_NONE, "R10 wide param write");
        acc(1, 1, 0, 3'd0, 16'h0004, 0, 0, E_NONE, "R10 bad control offset");
        check("R10 srst untouched", 16'(srst_active), 16'd0);
        acc(0, 0, 0, 3'd2, 0, 1, 16'h0052, E_NONE, "R10 param untouched");
        check("R10 acc_err sticky", 16'(acc_err), 16'd1);

        // R1 again after a second reset
        do_reset();
        @(negedge clk);
        check("R1 acc_err cleared", 16'(acc_err), 16'd0);
        check("R1 cmd_code cleared", 16'(cmd_code), 16'd0);
        acc(0, 1, 0, 3'd6, 0, 1, 16'h0040, E_NONE, "R1 alt status after reset");
        repeat (3) @(negedge clk);
        finish_run();
    end
endmodule